// File: doc/BRIEF.md
# Peripheral Register Window Decoder

This block sits between a CPU data port and the control-register region of a chip. It decodes each access, picks one of ten peripheral register banks by address, enforces the bank's address limit and the per-register size permissions, and returns read data in the same cycle. Registers that a peripheral implements itself are not stored here. Accesses to them are passed out on a side port, and for reads the data that comes back on that port is returned.

Only the top 3 address bits are discarded. A bank is chosen by the 13-bit page in bits [28:16], and the register inside the bank by bits [7:2]. Local registers are plain storage. A narrow write replaces only the low byte or the low half-word, and a narrow read returns the low part of the register with zeros above it. Two write-only DRAM-mode pages, any unmatched page, and any out-of-range offset all read as zero and ignore writes.

Top module: `periph_reg_window`

## Requirements
- R1: Address bits [31:29] are ignored. Two addresses that differ only there reach the same register with the same result.
- R2: Pages (bits [28:16]) map to banks 0..9 as follows: 0x1F00, 0x1F20, 0x1F80, 0x1FA0, 0x1FC0, 0x1FC8, 0x1FD0, 0x1FD8, 0x1FE0, 0x1FE8. The register index is bits [7:2]. Each (bank, index) is distinct storage.
- R3: A bank accepts a read only when the 16-bit offset (bits [15:0]) is at most the bank's read top. The read tops are 0x44, 0x20, 0x48, 0x40, 0x10, 0x3C, 0x10, 0x2C, 0x1C and 0x24 for banks 0..9. Any other read returns zero and raises no external request.
- R4: Write tops equal read tops except for bank 0 (0x3C) and bank 6 (0x0C). A write beyond the write top changes nothing and raises no external request.
- R5: Pages 0x1F90 and 0x1F94 are write-only holes. Reads return zero, and writes have no effect and raise no external request.
- R6: The size code is 0 for a byte, 1 for a half-word, 2 for a word, and 3 for a size nothing allows. A word is legal at any index. A half-word is legal only at an even index. A byte is legal only at an index that is a multiple of 4. An illegal-size access is ignored, and a read of that kind returns zero.
- R7: A local byte write updates bits [7:0] and a local half-word write updates bits [15:0]. Other bits are kept. A local read returns the register truncated to the access size and zero-extended.
- R8: Reads of index 2 and writes of index 2 or 3 are forwarded when in range and size-legal. In that case ext_valid_o rises while valid_i is high, the external port carries the write flag, the masked address, the size and the write data, and a forwarded read returns ext_rdata_i unchanged. Forwarded writes leave local storage untouched.
- R9: An address whose page matches no bank and no hole reads as zero, ignores writes and raises no external request.
- R10: Reset clears every local register to zero.
- R11: Read data follows the inputs in the same cycle. A local write becomes visible on the clock edge after the strobe, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| size_i | input | 2 | Access size code |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| ext_valid_o | output | 1 | Forwarded access request |
| ext_we_o | output | 1 | Forwarded access is a write |
| ext_addr_o | output | 29 | Masked address of forwarded access |
| ext_size_o | output | 2 | Size code of forwarded access |
| ext_wdata_o | output | 32 | Write data of forwarded access |
| ext_rdata_i | input | 32 | Read data returned for a forwarded read |

## Verification
A wrong page comparator or limit constant shows up in the same cycle on rdata_o. Depending on the fault, an in-range register reads zero, or an offset just past the top reads back stored data. A write strobe that reaches the wrong bank, or that escapes a size, limit or forwarding check, corrupts storage. That corruption only shows on a later read of the victim register, so every write phase is followed by a full read sweep of all banks, including one index past each top. Forwarding faults appear on ext_valid_o during the strobe cycle itself.

// File: rtl/prw_pkg.sv
package prw_pkg;
  localparam int NUM_BANKS = 10;
  localparam int NUM_HOLES = 2;
  localparam int PAGE_W    = 13;
  localparam int OFF_W     = 16;
  localparam int IDX_W     = 6;
  localparam int DATA_W    = 32;
  localparam int MADDR_W   = 29;
  localparam int BSEL_W    = $clog2(NUM_BANKS);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  function automatic logic [PAGE_W-1:0] bank_page(int b);
    case (b)
      0: return 13'h1F00;
      1: return 13'h1F20;
      2: return 13'h1F80;
      3: return 13'h1FA0;
      4: return 13'h1FC0;
      5: return 13'h1FC8;
      6: return 13'h1FD0;
      7: return 13'h1FD8;
      8: return 13'h1FE0;
      default: return 13'h1FE8;
    endcase
  endfunction

  function automatic logic [OFF_W-1:0] bank_rd_top(int b);
    case (b)
      0: return 16'h0044;
      1: return 16'h0020;
      2: return 16'h0048;
      3: return 16'h0040;
      4: return 16'h0010;
      5: return 16'h003C;
      6: return 16'h0010;
      7: return 16'h002C;
      8: return 16'h001C;
      default: return 16'h0024;
    endcase
  endfunction

  // writes stop short of the read top on two banks
  function automatic logic [OFF_W-1:0] bank_wr_top(int b);
    case (b)
      0: return 16'h003C;
      6: return 16'h000C;
      default: return bank_rd_top(b);
    endcase
  endfunction

  function automatic int bank_nregs(int b);
    return int'(bank_rd_top(b)) / 4 + 1;
  endfunction

  function automatic logic [PAGE_W-1:0] hole_page(int h);
    return (h == 0) ? 13'h1F90 : 13'h1F94;
  endfunction

  function automatic logic size_ok(logic [IDX_W-1:0] idx, logic [1:0] sz);
    case (sz)
      SZ_WORD: return 1'b1;
      SZ_HALF: return ~idx[0];
      SZ_BYTE: return idx[1:0] == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic rd_ext(logic [IDX_W-1:0] idx);
    return idx == 6'd2;
  endfunction

  function automatic logic wr_ext(logic [IDX_W-1:0] idx);
    return (idx == 6'd2) || (idx == 6'd3);
  endfunction
endpackage

// File: rtl/prw_decode.sv
module prw_decode
  import prw_pkg::*;
#(
  parameter int NB = NUM_BANKS,
  parameter int NH = NUM_HOLES,
  parameter int SW = BSEL_W
) (
  input  logic [MADDR_W-1:0] addr_i,
  output logic [NB-1:0]      bank_hit_o,
  output logic [SW-1:0]      bank_sel_o,
  output logic               rd_ok_o,
  output logic               wr_ok_o,
  output logic               hole_o,
  output logic [IDX_W-1:0]   reg_idx_o
);
  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  off;
  logic [NB-1:0]     rd_in, wr_in;
  logic [NH-1:0]     hole_vec;

  assign page      = addr_i[MADDR_W-1:OFF_W];
  assign off       = addr_i[OFF_W-1:0];
  assign reg_idx_o = off[IDX_W+1:2];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign bank_hit_o[g] = (page == bank_page(g));
    assign rd_in[g]      = (off <= bank_rd_top(g));
    assign wr_in[g]      = (off <= bank_wr_top(g));
  end

  for (genvar h = 0; h < NH; h++) begin : g_hole
    assign hole_vec[h] = (page == hole_page(h));
  end

  always_comb begin
    bank_sel_o = '0;
    for (int i = 0; i < NB; i++) begin
      if (bank_hit_o[i]) bank_sel_o = SW'(i);
    end
  end

  assign rd_ok_o = |(bank_hit_o & rd_in);
  assign wr_ok_o = |(bank_hit_o & wr_in);
  assign hole_o  = |hole_vec;
endmodule

// File: rtl/prw_reg_bank.sv
module prw_reg_bank
  import prw_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int DW    = DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       size_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int IW = $clog2(NREGS);
  localparam logic [IDX_W-1:0] NREGS_L = IDX_W'(NREGS);

  logic [DW-1:0] regs [NREGS];
  logic [IW-1:0] loc;
  logic          in_rng;
  logic          unused_idx;

  assign loc        = idx_i[IW-1:0];
  assign in_rng     = idx_i < NREGS_L;
  assign unused_idx = ^idx_i[IDX_W-1:IW];
  assign rdata_o    = in_rng ? regs[loc] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we_i && in_rng) begin
      case (size_i)
        SZ_BYTE: regs[loc][7:0]  <= wdata_i[7:0];
        SZ_HALF: regs[loc][15:0] <= wdata_i[15:0];
        SZ_WORD: regs[loc]       <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/periph_reg_window.sv
module periph_reg_window
  import prw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DW     = DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         size_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               ext_valid_o,
  output logic               ext_we_o,
  output logic [MADDR_W-1:0] ext_addr_o,
  output logic [1:0]         ext_size_o,
  output logic [DW-1:0]      ext_wdata_o,
  input  logic [DW-1:0]      ext_rdata_i
);
  logic [MADDR_W-1:0]   maddr;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [BSEL_W-1:0]    bank_sel;
  logic                 rd_ok, wr_ok, hole_hit;
  logic [IDX_W-1:0]     reg_idx;
  logic                 sz_ok, rd_fwd, wr_fwd, rd_local, wr_local;
  logic [DW-1:0]        bank_rd [NUM_BANKS];
  logic [DW-1:0]        loc_word;
  logic                 unused_hi;

  assign maddr     = addr_i[MADDR_W-1:0];
  assign unused_hi = ^addr_i[ADDR_W-1:MADDR_W];

  prw_decode u_dec (
    .addr_i     (maddr),
    .bank_hit_o (bank_hit),
    .bank_sel_o (bank_sel),
    .rd_ok_o    (rd_ok),
    .wr_ok_o    (wr_ok),
    .hole_o     (hole_hit),
    .reg_idx_o  (reg_idx)
  );

  assign sz_ok    = size_ok(reg_idx, size_i);
  assign rd_fwd   = rd_ok & sz_ok & rd_ext(reg_idx) & ~hole_hit;
  assign wr_fwd   = wr_ok & sz_ok & wr_ext(reg_idx) & ~hole_hit;
  assign rd_local = rd_ok & sz_ok & ~rd_ext(reg_idx) & ~hole_hit;
  assign wr_local = valid_i & we_i & wr_ok & sz_ok & ~wr_ext(reg_idx) & ~hole_hit;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam int NR = bank_nregs(g);
    prw_reg_bank #(.NREGS(NR), .DW(DW)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_local & bank_hit[g]),
      .idx_i   (reg_idx),
      .size_i  (size_i),
      .wdata_i (wdata_i),
      .rdata_o (bank_rd[g])
    );
  end

  assign loc_word = bank_rd[bank_sel];

  always_comb begin
    rdata_o = '0;
    if (rd_fwd) begin
      rdata_o = ext_rdata_i;
    end else if (rd_local) begin
      case (size_i)
        SZ_BYTE: rdata_o = {{(DW-8){1'b0}}, loc_word[7:0]};
        SZ_HALF: rdata_o = {{(DW-16){1'b0}}, loc_word[15:0]};
        SZ_WORD: rdata_o = loc_word;
        default: rdata_o = '0;
      endcase
    end
  end

  assign ext_valid_o = valid_i & (we_i ? wr_fwd : rd_fwd);
  assign ext_we_o    = we_i;
  assign ext_addr_o  = maddr;
  assign ext_size_o  = size_i;
  assign ext_wdata_o = wdata_i;
endmodule

// File: rtl/prw_checker.sv
module prw_checker
  import prw_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic                 we_i,
  input logic [31:0]          addr_i,
  input logic [1:0]           size_i,
  input logic [31:0]          wdata_i,
  input logic [31:0]          rdata_o,
  input logic                 ext_valid_o,
  input logic [31:0]          ext_rdata_i,
  input logic [NUM_BANKS-1:0] bank_hit,
  input logic                 hole_hit,
  input logic                 wr_ok,
  input logic                 rd_fwd,
  input logic                 wr_local
);
  p_onehot_bank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_hit));

  p_ext_needs_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o |-> valid_i);

  p_fwd_rdata_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_valid_o && !we_i) |-> (rdata_o == ext_rdata_i));

  p_unmatched_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_hit == '0) |-> (rdata_o == '0 && !ext_valid_o));

  p_hole_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hole_hit |-> (rdata_o == '0 && !ext_valid_o));

  p_bad_size_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == SZ_NONE) |-> (rdata_o == '0 && !ext_valid_o && !wr_local));

  p_byte_zext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == SZ_BYTE && !rd_fwd) |-> (rdata_o[31:8] == '0));

  p_wr_beyond_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && we_i && !wr_ok) |-> (!ext_valid_o && !wr_local));

  p_write_visible_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_local) && $past(size_i) == SZ_WORD &&
     addr_i == $past(addr_i) && size_i == SZ_WORD && !rd_fwd)
    |-> (rdata_o == $past(wdata_i)));
endmodule

bind periph_reg_window prw_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .size_i      (size_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .ext_valid_o (ext_valid_o),
  .ext_rdata_i (ext_rdata_i),
  .bank_hit    (bank_hit),
  .hole_hit    (hole_hit),
  .wr_ok       (wr_ok),
  .rd_fwd      (rd_fwd),
  .wr_local    (wr_local)
);

// File: tb/sim_periph_reg_window.sv
module sim_periph_reg_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0, ext_rdata = '0;
  logic [1:0]  size = 2'd2;
  logic [31:0] rdata, ext_wdata;
  logic        ext_valid, ext_we;
  logic [28:0] ext_addr;
  logic [1:0]  ext_size;

  int total = 0, fails = 0;
  bit done = 0;
  logic [31:0] mem [10][19];

  always #5 clk = ~clk;

  periph_reg_window u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .ext_valid_o(ext_valid),
    .ext_we_o(ext_we), .ext_addr_o(ext_addr), .ext_size_o(ext_size),
    .ext_wdata_o(ext_wdata), .ext_rdata_i(ext_rdata)
  );

  function automatic logic [12:0] pg(int b);
    logic [12:0] t [10] = '{13'h1F00, 13'h1F20, 13'h1F80, 13'h1FA0, 13'h1FC0,
                            13'h1FC8, 13'h1FD0, 13'h1FD8, 13'h1FE0, 13'h1FE8};
    return t[b];
  endfunction
  function automatic int rtop(int b);
    int t [10] = '{68, 32, 72, 64, 16, 60, 16, 44, 28, 36};
    return t[b];
  endfunction
  function automatic int wtop(int b);
    return (b == 0) ? 60 : (b == 6) ? 12 : rtop(b);
  endfunction
  function automatic bit legal(int idx, int sz);
    return sz == 2 || (sz == 1 && idx % 2 == 0) || (sz == 0 && idx % 4 == 0);
  endfunction
  function automatic logic [31:0] mk_addr(int b, int idx, logic [2:0] hi);
    return {hi, pg(b), 8'h00, 6'(idx), 2'b00};
  endfunction
  function automatic logic [31:0] exp_rd(int b, int idx, int sz, logic [31:0] ext);
    if (idx * 4 > rtop(b) || !legal(idx, sz)) return '0;
    if (idx == 2) return ext;
    if (sz == 0) return {24'h0, mem[b][idx][7:0]};
    if (sz == 1) return {16'h0, mem[b][idx][15:0]};
    return mem[b][idx];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic v, logic w, logic [31:0] a, logic [1:0] s, logic [31:0] d);
    valid = v; we = w; addr = a; size = s; wdata = d;
    ext_rdata = {8'hEE, a[23:0]};
  endtask

  task automatic do_read(int b, int idx, int sz, logic [2:0] hi);
    logic [31:0] a = mk_addr(b, idx, hi);
    string tag;
    @(negedge clk);
    drive(1'b1, 1'b0, a, 2'(sz), '0);
    #1;
    if (idx * 4 > rtop(b)) tag = "R3 beyond read top";
    else if (!legal(idx, sz)) tag = "R6 size";
    else if (idx == 2) tag = "R8 fwd read";
    else if (sz != 2) tag = "R7 narrow read";
    else tag = (hi != 3'b000) ? "R1 masked read" : "R2 read";
    chk(tag, rdata, exp_rd(b, idx, sz, ext_rdata));
    chk("R8 read ext_valid", 32'(ext_valid),
        32'(idx * 4 <= rtop(b) && legal(idx, sz) && idx == 2));
  endtask

  task automatic do_write(int b, int idx, int sz, logic [2:0] hi, logic [31:0] d);
    logic [31:0] a = mk_addr(b, idx, hi);
    bit inr = idx * 4 <= wtop(b);
    bit fwd = inr && legal(idx, sz) && (idx == 2 || idx == 3);
    @(negedge clk);
    drive(1'b1, 1'b1, a, 2'(sz), d);
    #1;
    chk("R11 old value before edge", rdata, exp_rd(b, idx, sz, ext_rdata));
    chk(inr ? "R8 write ext_valid" : "R4 beyond write top", 32'(ext_valid), 32'(fwd));
    if (fwd) begin
      chk("R8 ext_we", 32'(ext_we), 32'd1);
      chk("R8 ext_addr", 32'(ext_addr), 32'(a[28:0]));
      chk("R8 ext_wdata", ext_wdata, d);
      chk("R8 ext_size", 32'(ext_size), 32'(sz));
    end
    if (inr && legal(idx, sz) && !fwd) begin
      if (sz == 0) mem[b][idx][7:0] = d[7:0];
      else if (sz == 1) mem[b][idx][15:0] = d[15:0];
      else mem[b][idx] = d;
    end
    @(posedge clk);
    #1;
    valid = 1'b0; we = 1'b0;
  endtask

  task automatic raw_access(logic [31:0] a, string tag);
    @(negedge clk);
    drive(1'b1, 1'b1, a, 2'd2, 32'hDEAD_BEEF);
    #1;
    chk(tag, 32'(ext_valid), 32'd0);
    @(negedge clk);
    drive(1'b1, 1'b0, a, 2'd2, '0);
    #1;
    chk(tag, rdata, 32'd0);
    chk(tag, 32'(ext_valid), 32'd0);
  endtask

  task automatic sweep_words();
    for (int b = 0; b < 10; b++)
      for (int i = 0; i <= rtop(b) / 4 + 1; i++)
        do_read(b, i, 2, 3'(i % 3 == 1 ? 3'b111 : 3'b000));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int b = 0; b < 10; b++)
      for (int i = 0; i < 19; i++) mem[b][i] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL R11 watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 10; b++)
      for (int i = 0; i < 19; i++) mem[b][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: all zero after reset
    sweep_words();
    // R2/R3/R4/R1: word writes, one past every top
    for (int b = 0; b < 10; b++)
      for (int i = 0; i <= rtop(b) / 4 + 1; i++)
        do_write(b, i, 2, 3'(i % 3 == 0 ? 3'b101 : 3'b000),
                 32'h1357_0000 ^ (32'(b) << 20) ^ (32'(i) << 8) ^ 32'(b * 7 + i));
    sweep_words();
    // R6/R7: narrow and illegal sizes
    for (int b = 0; b < 10; b++)
      for (int i = 0; i <= rtop(b) / 4 + 1; i++)
        for (int s = 0; s < 4; s++) begin
          if (s == 2) continue;
          do_write(b, i, s, 3'b000,
                   32'h5A00_0000 ^ (32'(b) << 16) ^ (32'(i) << 8) ^ 32'((s + 1) * 17));
          for (int r = 0; r < 4; r++) do_read(b, i, r, 3'b011);
        end
    // R5 holes, R9 unmatched, R3 offsets above the low byte
    raw_access(32'h1F90_0000, "R5 hole");
    raw_access(32'hFF94_0004, "R5 hole");
    raw_access(32'h1F10_0000, "R9 unmatched");
    raw_access(32'h1FF0_0008, "R9 unmatched");
    raw_access(32'h0000_0000, "R9 unmatched");
    raw_access(32'h1F80_0104, "R3 high offset");
    raw_access(32'h1FD0_0100, "R3 high offset");
    sweep_words();
    // R10: reset after traffic
    do_reset();
    sweep_words();
    done = 1;
    summary();
    $finish;
  end
endmodule